// File: doc/BRIEF.md
# Two-Event Class Sequencer for a PoE Power-Sourcing Port

This block sequences the classification phase of one Power over Ethernet source port. Once detection has found a valid powered device, a start request launches a class pulse: the block raises a request to the analog front end and waits for a class result (0 to 4) to come back on a valid strobe. A result of 0 to 3 ends classification at once and the port is granted power as a single-event (Type 1) device.

When the port's two-event enable is set and the first result is Class 4, the block holds the port at the mark-voltage level for a programmable number of clock cycles and then issues a second class pulse. It sets a high-power flag when this second pulse begins. A second Class 4 grants power. A Class 4 followed by any lower class is an invalid high-power signature: power is withheld and a detection restart is requested. The status class field always shows the most recent class result, so after an invalid pair it shows the second one.

Top module: `poe_cls_seq`

## Requirements
- R1: A synchronous reset returns the block to idle: class_req_o, mark_o, power_grant_o and restart_det_o are 0, and stat_class_o and stat_hp_o both read 0.
- R2: start_i seen in idle raises class_req_o on the next cycle, and class_req_o stays high until a result is accepted (res_valid_i high while class_req_o is high).
- R3: If the first result is Class 0 to 3 (binary 3'd0 to 3'd3 on res_class_i), or Class 4 (3'd4) with twoevt_en_i low, power_grant_o pulses in the cycle after acceptance, mark_o stays low and no second pulse is run.
- R4: If the first result is Class 4 with twoevt_en_i high, mark_o is high for exactly MARK_CYCLES cycles starting the cycle after acceptance, class_req_o is low throughout, and class_req_o rises again in the cycle after mark_o falls.
- R5: stat_hp_o goes to 1 when the second class pulse begins (together with class_req_o rising after the mark interval) and returns to 0 when the next start is accepted.
- R6: A second result of Class 4 produces power_grant_o; a second result of Class 0 to 3 produces restart_det_o and no power_grant_o.
- R7: stat_class_o shows the most recently accepted class result from the cycle after acceptance, and keeps it until the next accepted result.
- R8: Each completed classification gives exactly one one-cycle pulse on either power_grant_o or restart_det_o, never both.
- R9: res_valid_i while class_req_o is low is ignored: stat_class_o, the outputs and the sequence are unchanged.
- R10: start_i while a classification is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start classification (detection succeeded) |
| twoevt_en_i | input | 1 | Enable the two-event sequence for this port |
| res_valid_i | input | 1 | Class result strobe from the front end |
| res_class_i | input | 3 | Class result, binary 0 to 4 |
| class_req_o | output | 1 | Class pulse request to the front end |
| mark_o | output | 1 | Hold the port at the mark-voltage level |
| power_grant_o | output | 1 | One-cycle pulse: power the port |
| restart_det_o | output | 1 | One-cycle pulse: restart detection |
| stat_class_o | output | 3 | Status field: last accepted class result |
| stat_hp_o | output | 1 | Status flag: second class pulse was run |

## Verification
The assertions take for granted that res_class_i carries a value from 0 to 4 whenever res_valid_i is high; codes 5 to 7 are outside the contract. The stimulus draws every class value from 0 to 4, and uses stray result strobes and start requests at the awkward moments (idle, mark interval, waiting for a result) because those are legal and must be ignored. The mark interval is shortened through its parameter so that the bench can count every mark cycle.

// File: rtl/poe_cls_pkg.sv
package poe_cls_pkg;

    localparam int CLASS_W = 3;

    typedef logic [CLASS_W-1:0] cls_t;

    localparam cls_t CLASS_HI = cls_t'(4);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE1,
        ST_MARK,
        ST_PULSE2
    } seq_state_t;

    function automatic logic is_hi_class(input cls_t c);
        return c == CLASS_HI;
    endfunction

    function automatic logic is_pulse_state(input seq_state_t s);
        return (s == ST_PULSE1) || (s == ST_PULSE2);
    endfunction

endpackage

// File: rtl/cls_mark_timer.sv
module cls_mark_timer #(
    parameter int MARK_CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(MARK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(MARK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/cls_ctrl_fsm.sv
module cls_ctrl_fsm
    import poe_cls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       twoevt_en,
    input  logic       res_valid,
    input  cls_t       res_class,
    input  logic       mark_done,
    output seq_state_t state,
    output logic       grant,
    output logic       restart,
    output logic       accept,
    output logic       start_acc,
    output logic       second_go
);
    seq_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant   <= 1'b0;
            restart <= 1'b0;
        end else begin
            grant   <= 1'b0;
            restart <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) state_q <= ST_PULSE1;
                end
                ST_PULSE1: begin
                    if (res_valid) begin
                        if (twoevt_en && is_hi_class(res_class)) begin
                            state_q <= ST_MARK;
                        end else begin
                            grant   <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_MARK: begin
                    if (mark_done) state_q <= ST_PULSE2;
                end
                ST_PULSE2: begin
                    if (res_valid) begin
                        if (is_hi_class(res_class)) grant <= 1'b1;
                        else                        restart <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state     = state_q;
    assign accept    = res_valid && is_pulse_state(state_q);
    assign start_acc = start && (state_q == ST_IDLE);
    assign second_go = mark_done && (state_q == ST_MARK);
endmodule

// File: rtl/cls_status_reg.sv
module cls_status_reg
    import poe_cls_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  cls_t res_class,
    input  logic start_acc,
    input  logic second_go,
    output cls_t last_class,
    output logic hp_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            last_class <= '0;
            hp_flag    <= 1'b0;
        end else begin
            if (accept)         last_class <= res_class;
            if (start_acc)      hp_flag    <= 1'b0;
            else if (second_go) hp_flag    <= 1'b1;
        end
    end
endmodule

// File: rtl/poe_cls_seq.sv
module poe_cls_seq
    import poe_cls_pkg::*;
#(
    parameter int MARK_CYCLES = 2500000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               twoevt_en_i,
    input  logic               res_valid_i,
    input  logic [CLASS_W-1:0] res_class_i,
    output logic               class_req_o,
    output logic               mark_o,
    output logic               power_grant_o,
    output logic               restart_det_o,
    output logic [CLASS_W-1:0] stat_class_o,
    output logic               stat_hp_o
);
    seq_state_t state;
    logic       accept;
    logic       start_acc;
    logic       second_go;
    logic       mark_done;

    cls_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .twoevt_en (twoevt_en_i),
        .res_valid (res_valid_i),
        .res_class (res_class_i),
        .mark_done (mark_done),
        .state     (state),
        .grant     (power_grant_o),
        .restart   (restart_det_o),
        .accept    (accept),
        .start_acc (start_acc),
        .second_go (second_go)
    );

    cls_mark_timer #(.MARK_CYCLES(MARK_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_MARK),
        .done (mark_done)
    );

    cls_status_reg u_stat (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .res_class  (res_class_i),
        .start_acc  (start_acc),
        .second_go  (second_go),
        .last_class (stat_class_o),
        .hp_flag    (stat_hp_o)
    );

    assign class_req_o = is_pulse_state(state);
    assign mark_o      = (state == ST_MARK);
endmodule

// File: rtl/poe_cls_seq_chk.sv
module poe_cls_seq_chk #(
    parameter int MARK_CYCLES = 2500000
) (
    input logic       clk,
    input logic       rst,
    input logic       res_valid_i,
    input logic [2:0] res_class_i,
    input logic       class_req_o,
    input logic       mark_o,
    input logic       power_grant_o,
    input logic       restart_det_o,
    input logic [2:0] stat_class_o,
    input logic       stat_hp_o
);
    localparam int CW = $clog2(MARK_CYCLES + 1);
    logic [CW-1:0] mark_seen;

    always_ff @(posedge clk) begin
        if (rst || !mark_o) mark_seen <= '0;
        else                mark_seen <= mark_seen + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!class_req_o && !mark_o && !power_grant_o && !restart_det_o
                 && stat_class_o == 3'd0 && !stat_hp_o)); // R1
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (class_req_o && !res_valid_i) |=> class_req_o); // R2
    AST_GRANT_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
        power_grant_o |-> $past(class_req_o && res_valid_i)); // R3
    AST_MARK_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !(mark_o && class_req_o)); // R4
    AST_MARK_BOUND: assert property (@(posedge clk) disable iff (rst)
        mark_o |-> (int'(mark_seen) < MARK_CYCLES)); // R4
    AST_HP_ON_SECOND: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_hp_o) |-> (class_req_o && $past(mark_o))); // R5
    AST_RESTART_INVALID: assert property (@(posedge clk) disable iff (rst)
        restart_det_o |-> (stat_hp_o && stat_class_o != 3'd4)); // R6
    AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(class_req_o && res_valid_i) |=> $stable(stat_class_o)); // R7
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(power_grant_o && restart_det_o)); // R8
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
        (power_grant_o || restart_det_o) |=> !(power_grant_o || restart_det_o)); // R8
endmodule

bind poe_cls_seq poe_cls_seq_chk #(.MARK_CYCLES(MARK_CYCLES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .res_valid_i   (res_valid_i),
    .res_class_i   (res_class_i),
    .class_req_o   (class_req_o),
    .mark_o        (mark_o),
    .power_grant_o (power_grant_o),
    .restart_det_o (restart_det_o),
    .stat_class_o  (stat_class_o),
    .stat_hp_o     (stat_hp_o)
);

// File: tb/poe_cls_seq_tb.sv
module poe_cls_seq_tb_top;
    localparam int MARK = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       twoevt_en_i = 1'b0;
    logic       res_valid_i = 1'b0;
    logic [2:0] res_class_i = 3'd0;
    logic       class_req_o, mark_o, power_grant_o, restart_det_o, stat_hp_o;
    logic [2:0] stat_class_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    poe_cls_seq #(.MARK_CYCLES(MARK)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .twoevt_en_i(twoevt_en_i),
        .res_valid_i(res_valid_i), .res_class_i(res_class_i),
        .class_req_o(class_req_o), .mark_o(mark_o),
        .power_grant_o(power_grant_o), .restart_det_o(restart_det_o),
        .stat_class_o(stat_class_o), .stat_hp_o(stat_hp_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit two_event(input bit en, input int c1);
        return en && (c1 == 4);
    endfunction

    function automatic bit exp_grant(input bit en, input int c1, input int c2);
        return !two_event(en, c1) || (c2 == 4);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_idle_outputs(input string tag);
        chk(!class_req_o && !mark_o && !power_grant_o && !restart_det_o,
            tag, {class_req_o, mark_o, power_grant_o, restart_det_o}, 0);
    endtask

    task automatic give_result(input int c);
        res_valid_i = 1'b1;
        res_class_i = 3'(c);
        tick();
        res_valid_i = 1'b0;
    endtask

    task automatic classify(input bit en, input int c1, input int c2,
                            input int wait1, input bit pokes);
        int n;
        bit g;
        twoevt_en_i = en;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk(class_req_o == 1'b1, "R2 req after start", class_req_o, 1);
        chk(stat_hp_o == 1'b0, "R5 flag cleared on start", stat_hp_o, 0);
        for (int i = 0; i < wait1; i++) begin
            if (pokes && i == 0) start_i = 1'b1;
            tick();
            start_i = 1'b0;
            chk(class_req_o && !mark_o, "R2 R10 req held", class_req_o, 1);
        end
        give_result(c1);
        chk(stat_class_o == 3'(c1), "R7 class after first", stat_class_o, c1);
        if (two_event(en, c1)) begin
            chk(!power_grant_o && !restart_det_o, "R4 no outcome yet",
                power_grant_o, 0);
            n = 0;
            while (mark_o && n < 50) begin
                n++;
                chk(!class_req_o, "R4 no req in mark", class_req_o, 0);
                if (pokes && n == 2) begin
                    start_i = 1'b1;
                    res_valid_i = 1'b1;
                    res_class_i = 3'd1;
                end
                tick();
                start_i = 1'b0;
                res_valid_i = 1'b0;
                if (pokes && n == 2) begin
                    chk(stat_class_o == 3'd4, "R9 stray result in mark",
                        stat_class_o, 4);
                    chk(mark_o == 1'b1, "R10 start in mark", mark_o, 1);
                end
            end
            chk(n == MARK, "R4 mark length", n, MARK);
            chk(class_req_o == 1'b1, "R4 second req", class_req_o, 1);
            chk(stat_hp_o == 1'b1, "R5 flag set", stat_hp_o, 1);
            give_result(c2);
            chk(stat_class_o == 3'(c2), "R7 class after second", stat_class_o, c2);
        end else begin
            chk(!mark_o && stat_hp_o == 1'b0, "R3 no mark", mark_o, 0);
        end
        g = exp_grant(en, c1, c2);
        chk(power_grant_o == g, "R3 R6 grant", power_grant_o, g);
        chk(restart_det_o == !g, "R6 restart", restart_det_o, !g);
        tick();
        chk(!power_grant_o && !restart_det_o, "R8 one cycle",
            power_grant_o + restart_det_o, 0);
        chk(!class_req_o, "R8 back to idle", class_req_o, 0);
    endtask

    initial begin
        int c1, c2, sv;
        bit en;
        void'($urandom(32'd4266));
        tick(); tick();
        rst = 1'b0;
        tick();
        check_idle_outputs("R1 reset state");
        chk(stat_class_o == 0 && stat_hp_o == 0, "R1 status clear",
            stat_class_o, 0);

        // stray result in idle
        give_result(3);
        check_idle_outputs("R9 stray result idle");
        chk(stat_class_o == 3'd0, "R9 status kept", stat_class_o, 0);

        // directed corners
        classify(1'b0, 4, 0, 0, 1'b0);   // mode off, class 4: single pulse
        classify(1'b1, 2, 0, 1, 1'b1);   // mode on, low class
        classify(1'b1, 4, 4, 2, 1'b1);   // valid high-power pair
        classify(1'b1, 4, 2, 0, 1'b0);   // invalid pair
        chk(stat_class_o == 3'd2 && stat_hp_o, "R7 invalid pair reports second",
            stat_class_o, 2);
        give_result(4);
        chk(stat_class_o == 3'd2, "R9 idle stray after pair", stat_class_o, 2);
        classify(1'b1, 0, 0, 0, 1'b0);   // flag cleared by new start

        // mid-sequence reset
        twoevt_en_i = 1'b1;
        start_i = 1'b1; tick(); start_i = 1'b0;
        give_result(4);
        tick();
        rst = 1'b1; tick(); rst = 1'b0;
        check_idle_outputs("R1 reset in mark");
        chk(stat_class_o == 0 && !stat_hp_o, "R1 status reset", stat_class_o, 0);

        // constrained random
        for (int k = 0; k < 60; k++) begin
            en = 1'($urandom_range(0, 1));
            c1 = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 3)) : 4;
            c2 = int'($urandom_range(0, 4));
            sv = int'($urandom_range(0, 3));
            classify(en, c1, c2, sv, 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) begin
                give_result(int'($urandom_range(0, 4)));
                chk(!power_grant_o && !restart_det_o && !class_req_o,
                    "R9 random stray", power_grant_o, 0);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule